// File: doc/BRIEF.md
# Synchronous Rectifier Soft-Start Rising-Edge Ramp

During soft start, this block sets the rising-edge position of a synchronous-rectifier PWM output. Positions are counted in 40 ns time steps inside one switching period. Index 0 is the start of the period and `prd_last` is the last index.

When a soft start is launched, the rising edge is placed on the falling edge, so the output starts at zero duty cycle. The edge then moves one step earlier after every 1, 4, 16 or 64 switching periods, and stops once it equals the programmed target. The falling edge is only an input here and is never changed. If the edge steps past index 0, it continues from the last index of the period. With ramping switched off, the target edge is used directly.

A PWM generator reads `rise_edge` once per period. Updates happen only on the period-start pulse, so the value it reads never changes partway through a period.

Top module: `sr_ss_rise_ramp`

## Requirements
- R1: While `rst_n` is low, and after its release, `rise_edge` is 0 and `ramp_done` is 0.
- R2: With `ramp_en` high, a period-start cycle that sees a launch sets `rise_edge` to `fall_edge` on the next cycle. A launch is `ss_launch` high in that cycle, or held over from an earlier cycle. On the same cycle, `ramp_done` becomes 1 only if `fall_edge` equals `target_edge`.
- R3: While ramping and not done, the edge moves one index lower on every N-th period-start after the launch. N is 1, 4, 16 or 64 for `step_code` values 0, 1, 2 and 3.
- R4: A step taken from index 0 sets `rise_edge` to `prd_last`.
- R5: After a step makes `rise_edge` equal `target_edge`, `ramp_done` goes to 1. From then on, `rise_edge` holds until the next launch or mode change.
- R6: `rise_edge` and `ramp_done` change only on the cycle after a `period_start` pulse.
- R7: With `ramp_en` low, each period-start loads `target_edge` into `rise_edge` and sets `ramp_done` to 1. A pending launch is discarded, so a later period-start with `ramp_en` high does not restart the ramp.
- R8: An `ss_launch` pulse between period starts leaves the outputs unchanged until the next `period_start`. It takes effect there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_start | input | 1 | One-cycle pulse at the start of each switching period |
| ramp_en | input | 1 | 1: ramp the edge during soft start; 0: use the target directly |
| ss_launch | input | 1 | Pulse that starts a new soft start |
| step_code | input | 2 | Step interval: 0→1, 1→4, 2→16, 3→64 periods |
| prd_last | input | EDGE_W | Last step index of the period (wrap destination) |
| fall_edge | input | EDGE_W | Fixed falling-edge index |
| target_edge | input | EDGE_W | Final rising-edge index |
| rise_edge | output | EDGE_W | Current rising-edge index |
| ramp_done | output | 1 | Target reached (or direct mode) |

## Verification
The bench builds the block with `EDGE_W` = 6, so a period has at most 64 steps. Random targets below the falling edge give straight descents. Random targets above the falling edge force the walk through index 0 and on to `prd_last`, which exercises the wrap in many runs. The step intervals 1, 4 and 16 are covered by random runs, and 64 by a short directed run. Launches land both on period-start cycles and between them, so the held-over launch path is exercised as well.

// File: rtl/sr_ramp_pkg.sv
package sr_ramp_pkg;
  localparam int CODE_W = 2;
  localparam int DIV_W  = 2 * ((1 << CODE_W) - 1);

  function automatic logic [DIV_W-1:0] interval_last(input logic [CODE_W-1:0] code);
    logic [DIV_W:0] span;
    span = ({{DIV_W{1'b0}}, 1'b1} << (2 * code));
    return span[DIV_W-1:0] - 1'b1;
  endfunction
endpackage

// File: rtl/sr_interval_div.sv
module sr_interval_div
  import sr_ramp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick   = adv && (cnt_q >= interval_last(code));
  assign cnt_en = clr || adv;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || tick) cnt_d = '0;
    else if (adv)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sr_edge_dec.sv
module sr_edge_dec #(
  parameter int EDGE_W = 10
) (
  input  logic [EDGE_W-1:0] cur,
  input  logic [EDGE_W-1:0] last,
  output logic [EDGE_W-1:0] nxt
);
  always_comb begin
    if (cur == '0) nxt = last;
    else           nxt = cur - 1'b1;
  end
endmodule

// File: rtl/sr_ss_rise_ramp.sv
module sr_ss_rise_ramp
  import sr_ramp_pkg::*;
#(
  parameter int EDGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_start,
  input  logic              ramp_en,
  input  logic              ss_launch,
  input  logic [CODE_W-1:0] step_code,
  input  logic [EDGE_W-1:0] prd_last,
  input  logic [EDGE_W-1:0] fall_edge,
  input  logic [EDGE_W-1:0] target_edge,
  output logic [EDGE_W-1:0] rise_edge,
  output logic              ramp_done
);
  logic [EDGE_W-1:0] edge_q, edge_d, edge_stepped;
  logic              done_q, done_d;
  logic              act_q, act_d;
  logic              pend_q, pend_d;
  logic              load, direct, adv, tick, upd_en;

  assign direct = period_start && !ramp_en;
  assign load   = period_start && ramp_en && (pend_q || ss_launch);
  assign adv    = period_start && ramp_en && !load && act_q && !done_q;
  assign upd_en = period_start || ss_launch;

  sr_interval_div u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load || direct),
    .adv   (adv),
    .code  (step_code),
    .tick  (tick)
  );

  sr_edge_dec #(.EDGE_W(EDGE_W)) u_dec (
    .cur  (edge_q),
    .last (prd_last),
    .nxt  (edge_stepped)
  );

  always_comb begin
    edge_d = edge_q;
    done_d = done_q;
    act_d  = act_q;
    pend_d = pend_q || ss_launch;
    if (direct) begin
      edge_d = target_edge;
      done_d = 1'b1;
      act_d  = 1'b0;
      pend_d = 1'b0;
    end else if (load) begin
      edge_d = fall_edge;
      done_d = (fall_edge == target_edge);
      act_d  = 1'b1;
      pend_d = 1'b0;
    end else if (tick) begin
      edge_d = edge_stepped;
      done_d = (edge_stepped == target_edge);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      done_q <= 1'b0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      edge_q <= edge_d;
      done_q <= done_d;
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  assign rise_edge = edge_q;
  assign ramp_done = done_q;
endmodule

// File: rtl/sr_ss_rise_ramp_chk.sv
module sr_ss_rise_ramp_chk #(
  parameter int EDGE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              period_start,
  input logic              ramp_en,
  input logic              ss_launch,
  input logic [EDGE_W-1:0] prd_last,
  input logic [EDGE_W-1:0] fall_edge,
  input logic [EDGE_W-1:0] target_edge,
  input logic [EDGE_W-1:0] rise_edge,
  input logic              ramp_done,
  input logic              pend,
  input logic              act
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (rise_edge == '0 && !ramp_done);
    end
  end

  assert_launch_zero_duty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && ramp_en && ss_launch) |=> (rise_edge == $past(fall_edge)));

  assert_wrap_to_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && ramp_en && !ss_launch && !pend && act && !ramp_done && rise_edge == '0)
      |=> (rise_edge == '0 || rise_edge == $past(prd_last)));

  assert_hold_when_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && ramp_en && !ss_launch && !pend && ramp_done)
      |=> ($stable(rise_edge) && ramp_done));

  assert_only_at_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> ($stable(rise_edge) && $stable(ramp_done)));

  assert_direct_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && !ramp_en) |=> (rise_edge == $past(target_edge) && ramp_done));
endmodule

bind sr_ss_rise_ramp sr_ss_rise_ramp_chk #(.EDGE_W(EDGE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .period_start (period_start),
  .ramp_en      (ramp_en),
  .ss_launch    (ss_launch),
  .prd_last     (prd_last),
  .fall_edge    (fall_edge),
  .target_edge  (target_edge),
  .rise_edge    (rise_edge),
  .ramp_done    (ramp_done),
  .pend         (pend_q),
  .act          (act_q)
);

// File: tb/tb_sr_ss_rise_ramp.sv
module tb_sr_ss_rise_ramp;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         period_start, ramp_en, ss_launch;
  logic [1:0]   step_code;
  logic [W-1:0] prd_last, fall_edge, target_edge;
  logic [W-1:0] rise_edge;
  logic         ramp_done;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // bench reference state
  int m_edge, m_cnt;
  bit m_done, m_act, m_pend;

  always #10 clk = ~clk;

  sr_ss_rise_ramp #(.EDGE_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .period_start(period_start), .ramp_en(ramp_en),
    .ss_launch(ss_launch), .step_code(step_code), .prd_last(prd_last),
    .fall_edge(fall_edge), .target_edge(target_edge),
    .rise_edge(rise_edge), .ramp_done(ramp_done)
  );

  function automatic int span_of(input int code);
    return 1 << (2 * code);
  endfunction

  function automatic int step_down(input int e, input int last);
    return (e == 0) ? last : e - 1;
  endfunction

  task automatic check(input string req);
    n_chk++;
    if (rise_edge !== m_edge[W-1:0] || ramp_done !== m_done) begin
      n_bad++;
      $display("FAIL %s: edge=%0d done=%0b expected edge=%0d done=%0b",
               req, rise_edge, ramp_done, m_edge, m_done);
    end
  endtask

  // reference update at a period-start cycle
  task automatic model_period(input bit launch_now);
    if (!ramp_en) begin
      m_edge = target_edge; m_done = 1; m_act = 0; m_pend = 0; m_cnt = 0;
    end else if (m_pend || launch_now) begin
      m_edge = fall_edge; m_done = (fall_edge == target_edge);
      m_act = 1; m_pend = 0; m_cnt = 0;
    end else if (m_act && !m_done) begin
      if (m_cnt + 1 >= span_of(step_code)) begin
        m_cnt = 0;
        m_edge = step_down(m_edge, prd_last);
        m_done = (m_edge == target_edge);
      end else m_cnt++;
    end
  endtask

  // idle cycles (edge must hold: R6), then one period-start cycle
  task automatic run_period(input int idle, input bit launch_now, input string req);
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      check("R6");
    end
    @(negedge clk);
    period_start = 1'b1;
    ss_launch = launch_now;
    model_period(launch_now);
    @(negedge clk);
    period_start = 1'b0;
    ss_launch = 1'b0;
    check(req);
  endtask

  // launch between period starts (R8)
  task automatic launch_mid();
    @(negedge clk);
    ss_launch = 1'b1;
    if (ramp_en) m_pend = 1;
    @(negedge clk);
    ss_launch = 1'b0;
    check("R8");
  endtask

  task automatic setup(input int last, input int fe, input int tg, input int code);
    prd_last = last[W-1:0]; fall_edge = fe[W-1:0];
    target_edge = tg[W-1:0]; step_code = code[1:0];
  endtask

  task automatic ramp_until_done(input int cap, input string req);
    for (int p = 0; p < cap && !m_done; p++)
      run_period(1 + ($urandom % 3), 1'b0, req);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    rst_n = 1'b0; period_start = 0; ramp_en = 1; ss_launch = 0;
    setup(19, 10, 5, 0);
    m_edge = 0; m_done = 0; m_act = 0; m_pend = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    // idle period starts without launch: nothing moves
    run_period(1, 1'b0, "R1");

    // R2 launch on period start, R3 code 0 straight descent, R5 done/hold
    run_period(1, 1'b1, "R2");
    ramp_until_done(40, "R3");
    check("R5");
    for (int k = 0; k < 3; k++) run_period(1, 1'b0, "R5");

    // R4 wrap: target above falling edge, code 1
    setup(19, 3, 17, 1);
    run_period(0, 1'b1, "R2");
    ramp_until_done(100, "R4");
    check("R4");

    // R3 code 3: a few steps only
    setup(30, 12, 10, 3);
    run_period(1, 1'b1, "R2");
    ramp_until_done(200, "R3");

    // R8 launch between period starts
    setup(40, 8, 6, 0);
    launch_mid();
    run_period(2, 1'b0, "R8");
    ramp_until_done(10, "R3");

    // R2 launch where falling edge equals target: done at once
    setup(40, 7, 7, 2);
    run_period(1, 1'b1, "R2");

    // R7 direct mode, and pending launch discarded
    ramp_en = 1'b0;
    setup(50, 30, 12, 0);
    launch_mid();
    run_period(1, 1'b0, "R7");
    target_edge = 6'd44;
    run_period(1, 1'b0, "R7");
    ramp_en = 1'b1;
    for (int k = 0; k < 3; k++) run_period(1, 1'b0, "R7");

    // constrained random soft starts
    for (int r = 0; r < 30; r++) begin
      int last, fe, tg, code;
      last = 8 + ($urandom % 56);
      fe   = $urandom % (last + 1);
      tg   = $urandom % (last + 1);
      code = $urandom % 3;
      setup(last, fe, tg, code);
      ramp_en = ($urandom % 8) != 0;
      if ($urandom % 2) begin
        launch_mid();
        run_period(1, 1'b0, "R8");
      end else run_period(1, 1'b1, "R2");
      ramp_until_done(1100, (tg > fe) ? "R4" : "R3");
      run_period(1, 1'b0, "R5");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule